// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs short commands on a serial flash device: status and identification reads, write enable, erase and short register writes. Software first loads an address register and two 32-bit write-data words, as the command needs them. It then writes a control word that carries the opcode, the enable and length of each optional phase, and an execute bit. The engine drives the chip select and shifts the command out on a single data lane. Returned bytes are collected into two 32-bit read-data words.

A command is made of phases that always come in the same order. The opcode is sent first. An address of one to four bytes follows if it is enabled. Then come dummy clocks, if any. Last come either up to eight write bytes or up to eight read bytes. The in-progress flag in the control word stays high from the cycle the command is accepted until the last serial clock of the last phase. While a command is pending or running, register writes are dropped.

The serial lane uses clock mode 0. The serial clock idles low. The output changes only while the clock is low, and input is sampled on each rising edge. Each half of a serial clock period lasts `HALF_CYC` system clocks.

Top module: `flash_cmd_engine`

## Requirements
- R1: A register write with `reg_wr_i` high stores `reg_wdata_i` in the register picked by `reg_sel_i`. The encoding is 0 control word, 1 address, 2 lower write data, 3 upper write data. `ctrl_o` returns the stored control word, except that bit 1 always shows the in-progress flag. All registers reset to zero.
- R2: Storing a control word with bit 0 (execute) set starts a command. One cycle later bit 0 reads 0, bit 1 (in-progress) reads 1 and `cs_n_o` is low.
- R3: While execute or in-progress is set, writes to every register are ignored. A control write that arrives during a command neither changes the control word nor starts a second command, and an address write made then is not used by the next command.
- R4: Bits are sent most significant first, with `sck_o` idle low and `mosi_o` changing only while `sck_o` is low. The first eight bits are the opcode in control bits 31:24.
- R5: When bit 19 is set, an address phase follows the opcode. Its length is (bits 17:16)+1 bytes, taken from the low-order bytes of the address register and sent most significant byte first.
- R6: Bits 11:7 give the number of dummy serial clocks, sent after the address with `mosi_o` low. A value of 0 means no dummy phase.
- R7: When bit 15 is set, (bits 14:12)+1 write bytes are sent after the dummy clocks. Byte k is taken from bits 8k+7:8k of the 64-bit value {upper, lower}, so byte 0 is the least significant byte of the lower word.
- R8: When bit 23 is set, (bits 22:20)+1 bytes are read from `miso_i`, each sampled most significant bit first. Received byte k is placed at bits 8k+7:8k of {`rd_hi_o`, `rd_lo_o`}, and every byte position at or above the count reads 0.
- R9: The read-data outputs change only in the cycle where the command ends (`cs_n_o` returns high), and only for commands that perform a read phase.
- R10: With bits 15 and 23 both set, the command is write-only: no read clocks are issued and the read-data outputs keep their old values.
- R11: A command lasts exactly 8 + 8·A + D + 8·N serial clocks, where A is the number of address bytes, D the number of dummy clocks and N the number of data bytes. This is 2·HALF_CYC system cycles per serial clock, after which in-progress drops and `cs_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select for the write |
| reg_wdata_i | input | 32 | Register write value |
| ctrl_o | output | 32 | Control word with live in-progress flag at bit 1 |
| rd_lo_o | output | 32 | Read data bytes 0 to 3 |
| rd_hi_o | output | 32 | Read data bytes 4 to 7 |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The assertions assume that software writes registers only through the strobe port. They also assume that the control-word fields never change by themselves between acceptance and completion. The bench keeps to this by writing registers from whole-cycle tasks on falling clock edges, and by making its deliberate writes during a command only to test that they are dropped. The flash model drives `miso_i` from a count of falling serial clock edges, so the input is always stable across the rising edge where the engine samples it. Outside the read window it holds a 1, so a wrongly timed sample shows up in the read data.

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine #(
  parameter int HALF_CYC = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] rd_lo_o,
  output logic [31:0] rd_hi_o,
  output logic        sck_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADDR, PH_DUMMY, PH_WR, PH_RD} ph_t;

  logic [31:0] ctrl_q, addr_q, wlo_q, whi_q, rlo_q, rhi_q;
  logic        busy_q, sck_q;
  ph_t         ph_q, nxt_ph, after_addr, after_dummy;
  logic [DIV_W-1:0] div_q;
  logic [6:0]  bits_q, ld_bits;
  logic [63:0] sr_q, ld_sr, in_q, in_fin, wswap, rd_pack;
  logic [5:0]  ash;

  wire [4:0] dummy_n = ctrl_q[11:7];
  wire [2:0] wr_n    = ctrl_q[14:12];
  wire       wr_on   = ctrl_q[15];
  wire [1:0] ab_n    = ctrl_q[17:16];
  wire       ad_on   = ctrl_q[19];
  wire [2:0] rd_n    = ctrl_q[22:20];
  wire       rd_on   = ctrl_q[23] & ~wr_on;
  wire [7:0] opc     = ctrl_q[31:24];
  wire       locked  = busy_q | ctrl_q[0];
  wire       start   = ctrl_q[0] & ~busy_q;
  wire       tick    = (div_q == DIV_LAST);

  assign ctrl_o  = {ctrl_q[31:2], busy_q, ctrl_q[0]};
  assign rd_lo_o = rlo_q;
  assign rd_hi_o = rhi_q;
  assign sck_o   = sck_q;
  assign cs_n_o  = ~busy_q;
  assign mosi_o  = busy_q & sr_q[63];
  assign in_fin  = {in_q[62:0], miso_i};
  assign ash     = {1'b0, ~ab_n, 3'b000};

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      wswap[8*(7-i) +: 8] = (i < 4) ? wlo_q[8*i +: 8] : whi_q[8*(i-4) +: 8];
      rd_pack[8*i +: 8]   = (i <= int'(rd_n)) ? in_fin[8*(int'(rd_n)-i) +: 8] : 8'h00;
    end
  end

  always_comb begin
    after_dummy = wr_on ? PH_WR : (rd_on ? PH_RD : PH_IDLE);
    after_addr  = (dummy_n != 5'd0) ? PH_DUMMY : after_dummy;
    case (ph_q)
      PH_OPC:   nxt_ph = ad_on ? PH_ADDR : after_addr;
      PH_ADDR:  nxt_ph = after_addr;
      PH_DUMMY: nxt_ph = after_dummy;
      default:  nxt_ph = PH_IDLE;
    endcase
  end

  always_comb begin
    ld_bits = 7'd8;
    ld_sr   = 64'h0;
    case (nxt_ph)
      PH_ADDR: begin
        ld_bits = 7'({ab_n, 3'b000}) + 7'd8;
        ld_sr   = {addr_q, 32'h0} << ash;
      end
      PH_DUMMY: ld_bits = {2'b00, dummy_n};
      PH_WR: begin
        ld_bits = 7'({wr_n, 3'b000}) + 7'd8;
        ld_sr   = wswap;
      end
      PH_RD:   ld_bits = 7'({rd_n, 3'b000}) + 7'd8;
      default: ld_bits = 7'd8;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
      rlo_q  <= '0;
      rhi_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      ph_q   <= PH_IDLE;
      div_q  <= '0;
      bits_q <= '0;
      sr_q   <= '0;
      in_q   <= '0;
    end else if (start) begin
      ctrl_q[0] <= 1'b0;
      busy_q    <= 1'b1;
      ph_q      <= PH_OPC;
      bits_q    <= 7'd8;
      sr_q      <= {opc, 56'h0};
      sck_q     <= 1'b0;
      div_q     <= '0;
      in_q      <= '0;
    end else if (busy_q) begin
      if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          sr_q  <= {sr_q[62:0], 1'b0};
          if (ph_q == PH_RD) in_q <= in_fin;
          if (bits_q == 7'd1) begin
            if (nxt_ph == PH_IDLE) begin
              busy_q <= 1'b0;
              ph_q   <= PH_IDLE;
              if (ph_q == PH_RD) begin
                rlo_q <= rd_pack[31:0];
                rhi_q <= rd_pack[63:32];
              end
            end else begin
              ph_q   <= nxt_ph;
              bits_q <= ld_bits;
              sr_q   <= ld_sr;
            end
          end else begin
            bits_q <= bits_q - 7'd1;
          end
        end
      end
    end else if (reg_wr_i && !locked) begin
      case (reg_sel_i)
        2'd0: ctrl_q <= reg_wdata_i & 32'hFFFF_FFFD;
        2'd1: addr_q <= reg_wdata_i;
        2'd2: wlo_q  <= reg_wdata_i;
        default: whi_q <= reg_wdata_i;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_engine_chk.sv
`timescale 1ns/1ps
module flash_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_o,
  input logic [31:0] rd_lo_o,
  input logic [31:0] rd_hi_o,
  input logic        sck_o,
  input logic        cs_n_o,
  input logic        mosi_o
);
  logic [63:0] rd_all;
  int          used_bits;
  assign rd_all    = {rd_hi_o, rd_lo_o};
  assign used_bits = 8 * (int'(ctrl_o[22:20]) + 1);

  assert_exec_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[0] && !ctrl_o[1]) |=> (!ctrl_o[0] && ctrl_o[1] && !cs_n_o));

  assert_ctrl_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[0] || ctrl_o[1]) |=> $stable(ctrl_o[31:2]));

  assert_mosi_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> $stable(mosi_o));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  assert_rd_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && ctrl_o[23] && !ctrl_o[15]) |-> ((rd_all >> used_bits) == 64'h0));

  assert_rd_only_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_lo_o) || !$stable(rd_hi_o)) |-> ($rose(cs_n_o) && ctrl_o[23] && !ctrl_o[15]));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_o(ctrl_o), .rd_lo_o(rd_lo_o), .rd_hi_o(rd_hi_o),
  .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o)
);

// File: tb/flash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic [31:0] reg_wdata_i = 32'h0;
  logic [31:0] ctrl_o, rd_lo_o, rd_hi_o;
  logic sck_o, cs_n_o, mosi_o, miso_i;

  always #10 clk = ~clk;

  flash_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .ctrl_o(ctrl_o), .rd_lo_o(rd_lo_o), .rd_hi_o(rd_hi_o),
    .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int checks = 0, fails = 0;
  int rise_cnt = 0, fall_cnt = 0, cs_cyc = 0;
  int rise_base = 0, fall_base = 0, cs_base = 0;
  logic mlog [0:255];
  logic ebits [0:255];
  int exp_n = 0, rd_start = 1000;
  logic [63:0] stream = 64'h0;
  logic [31:0] exp_lo = 32'h0, exp_hi = 32'h0;

  always @(posedge sck_o) begin
    mlog[(rise_cnt - rise_base) & 255] <= mosi_o;
    rise_cnt <= rise_cnt + 1;
  end
  always @(negedge sck_o) fall_cnt <= fall_cnt + 1;
  always @(posedge clk) if (!cs_n_o) cs_cyc <= cs_cyc + 1;

  always_comb begin
    int k;
    k = fall_cnt - fall_base - rd_start;
    miso_i = (k >= 0 && k < 64) ? stream[63 - k] : 1'b1;
  end

  localparam int NV = 8;
  localparam logic [191:0] VEC [NV] = '{
    {32'h0580_0001, 32'h0,         32'h0,         32'h0,         64'hA500_0000_0000_0000},
    {32'h9FA0_0001, 32'h0,         32'h0,         32'h0,         64'h20BA_1900_0000_0000},
    {32'h0600_0001, 32'h0,         32'h0,         32'h0,         64'h0},
    {32'hD80A_0001, 32'h0012_3456, 32'h0,         32'h0,         64'h0},
    {32'h120B_F281, 32'hCAFE_F00D, 32'h4433_2211, 32'h8877_6655, 64'h0},
    {32'h0BFA_0401, 32'h00AB_CDEF, 32'h0,         32'h0,         64'h0123_4567_89AB_CDEF},
    {32'h42B0_9001, 32'h0,         32'h0000_BEEF, 32'h0,         64'hFFFF_FFFF_FFFF_FFFF},
    {32'h4BC8_0001, 32'h0000_0077, 32'h0,         32'h0,         64'hDEAD_BEEF_5511_2233}
  };

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic build_exp(input logic [31:0] c, input logic [31:0] a,
                           input logic [31:0] lo, input logic [31:0] hi);
    int na, nd, nn, p;
    logic w, r;
    logic [63:0] wd;
    na = c[19] ? int'(c[17:16]) + 1 : 0;
    nd = int'(c[11:7]);
    w  = c[15];
    r  = c[23] && !c[15];
    nn = w ? int'(c[14:12]) + 1 : (r ? int'(c[22:20]) + 1 : 0);
    wd = {hi, lo};
    p = 0;
    for (int b = 7; b >= 0; b--) begin ebits[p] = c[24 + b]; p++; end
    for (int k = na - 1; k >= 0; k--)
      for (int b = 7; b >= 0; b--) begin ebits[p] = a[8*k + b]; p++; end
    for (int d = 0; d < nd; d++) begin ebits[p] = 1'b0; p++; end
    rd_start = r ? p : 1000;
    for (int k = 0; k < nn; k++)
      for (int b = 7; b >= 0; b--) begin ebits[p] = w ? wd[8*k + b] : 1'b0; p++; end
    exp_n = p;
    if (r) begin
      logic [63:0] all;
      all = 64'h0;
      for (int k = 0; k < nn; k++) all[8*k +: 8] = stream[63 - 8*k -: 8];
      exp_lo = all[31:0];
      exp_hi = all[63:32];
    end
  endtask

  task automatic start_cmd(input logic [31:0] c, input logic [31:0] a, input logic [31:0] lo,
                           input logic [31:0] hi, input logic [63:0] s, input logic load_regs);
    stream = s;
    build_exp(c, a, lo, hi);
    rise_base = rise_cnt; fall_base = fall_cnt; cs_base = cs_cyc;
    if (load_regs) begin
      wr(2'd1, a); wr(2'd2, lo); wr(2'd3, hi);
    end
    wr(2'd0, c);
    chk(ctrl_o[0] == 1'b1 && ctrl_o[1] == 1'b0, "R1 execute stored", {32'h0, ctrl_o}, {32'h0, c});
    @(negedge clk);
    chk(ctrl_o[1:0] == 2'b10 && cs_n_o == 1'b0, "R2 execute self-clears, busy set",
        {61'h0, cs_n_o, ctrl_o[1:0]}, 64'h2);
  endtask

  task automatic finish_cmd(input string tag);
    int guard, bad;
    logic [63:0] fa;
    guard = 0;
    while (!cs_n_o && guard < 20000) begin @(negedge clk); guard++; end
    chk(cs_n_o == 1'b1, "R11 command completes", {63'h0, cs_n_o}, 64'h1);
    chk((rise_cnt - rise_base) == exp_n, "R11 serial clock count",
        64'(rise_cnt - rise_base), 64'(exp_n));
    chk((cs_cyc - cs_base) == 2 * exp_n, "R11 busy cycle count",
        64'(cs_cyc - cs_base), 64'(2 * exp_n));
    bad = 0; fa = 64'h0;
    for (int i = 0; i < exp_n && i < 256; i++)
      if (i < rd_start && mlog[i] !== ebits[i]) begin
        if (bad == 0) fa = 64'(i);
        bad++;
      end
    chk(bad == 0, {tag, " R4 R5 R6 R7 serial stream, actual=first bad bit"}, fa, 64'(exp_n));
    chk(rd_lo_o == exp_lo && rd_hi_o == exp_hi, {tag, " R8 R9 R10 read data"},
        {rd_hi_o, rd_lo_o}, {exp_hi, exp_lo});
    chk(ctrl_o[1] == 1'b0, "R11 in-progress clear", {63'h0, ctrl_o[1]}, 64'h0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl_o == 32'h0 && rd_lo_o == 32'h0 && rd_hi_o == 32'h0, "R1 reset registers",
        {rd_hi_o, rd_lo_o | ctrl_o}, 64'h0);
    chk(cs_n_o == 1'b1 && sck_o == 1'b0, "R4 reset lane idle", {62'h0, cs_n_o, sck_o}, 64'h2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[v]) begin
      start_cmd(VEC[v][191:160], VEC[v][159:128], VEC[v][127:96], VEC[v][95:64], VEC[v][63:0], 1'b1);
      finish_cmd($sformatf("vec%0d", v));
    end

    // R3: writes during a command are dropped
    start_cmd(32'hD80A_0001, 32'h0011_1111, 32'h0, 32'h0, 64'h0, 1'b1);
    wr(2'd1, 32'h0022_2222);
    wr(2'd0, 32'h9FA0_0001);
    chk(ctrl_o == 32'hD80A_0002, "R3 control write ignored while busy",
        {32'h0, ctrl_o}, {32'h0, 32'hD80A_0002});
    finish_cmd("R3 erase");
    repeat (6) @(negedge clk);
    chk(cs_n_o == 1'b1 && ctrl_o[1:0] == 2'b00, "R3 no second command started",
        {61'h0, cs_n_o, ctrl_o[1:0]}, 64'h4);
    start_cmd(32'hD80A_0001, 32'h0011_1111, 32'h0, 32'h0, 64'h0, 1'b0);
    finish_cmd("R3 address write dropped R5");

    // R6: dummy-only command with the largest dummy count
    start_cmd(32'h6600_0F81, 32'h0, 32'h0, 32'h0, 64'h0, 1'b1);
    finish_cmd("R6 max dummy");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule